// File: doc/BRIEF.md
# Serial Memory Slave Front-End with Pause and Write Guard

This block is the serial front end of a memory slave on a four-wire SPI link. A fast system clock oversamples the link clock, chip select, pause pin, write-guard pin and serial input. Each pin passes through a two-flop synchroniser, and edges are found by comparing against one further delayed copy. Bits are taken in on the rising edge of the link clock, most significant bit first (SPI mode 0). The output bit changes on the falling edge. Each complete opcode byte is reported as a one-cycle strobe together with the byte value.

A pause pin (active low) freezes the bit sequence without losing its place. Entry and exit take effect only while the link clock is low. A change of the pause pin that arrives during the high phase waits for the next low phase. While paused, the serial output is released and link clock and data transitions are ignored. Raising chip select aborts everything, the pause included.

The block also holds an 8-bit status register. Its write instruction is guarded jointly by a write-guard pin and a lock bit held in the register itself.

Pause controller states:
- `HS_RUN`: normal operation.
- `HS_ENTER_WAIT`: pause requested while the link clock is high.
- `HS_PAUSED`: frozen.
- `HS_LEAVE_WAIT`: release requested while the link clock is high.

Pause controller transitions:
- run→paused when the pause pin is low with the link clock low.
- run→enter-wait when the pause pin is low with the link clock high.
- enter-wait→paused when the link clock goes low.
- enter-wait→run when the pause pin returns high.
- paused→run when the pause pin is high with the link clock low.
- paused→leave-wait when the pause pin is high with the link clock high.
- leave-wait→run when the link clock goes low.
- leave-wait→paused when the pause pin drops again.
- any state→run while chip select is high.

Command engine states:
- `CS_OPCODE`: collecting the first byte.
- `CS_WDATA`: collecting the status data byte.
- `CS_RDATA`: sending status.
- `CS_DISCARD`: ignoring bits.

Command engine transitions:
- opcode→wdata after an 8th bit equal to 0x01.
- opcode→rdata after an 8th bit equal to 0x05.
- opcode→discard after an 8th bit with any other value.
- wdata→discard after its 8th bit.
- any state→opcode while chip select is high.

Top module: `spi_hold_wp_front`

## Requirements
- R1: After reset the status register reads 0x00, the pause flag is 0, the output enable is 0 and the opcode strobe is 0.
- R2: Bits are captured MSB first on rising link-clock edges. After the 8th bit of a frame, the strobe pulses for one cycle and the opcode output shows the byte. An opcode other than 0x01 or 0x05 makes the rest of the frame be ignored until chip select rises.
- R3: Opcode 0x05 makes the block drive the status register on the serial output, MSB first. Each bit changes on a falling edge, and the byte repeats for as long as the clock runs. The output enable is 1 only in this phase and only while not paused.
- R4: Opcode 0x01 followed by a data byte writes the register. Only bit 7 (lock) and bits 3:2 (block-protect) take the data; all other bits always read 0.
- R5: With the write-guard pin high, a status write always executes.
- R6: With the write-guard pin low, a status write leaves the register unchanged if bit 7 is 1, and executes if bit 7 is 0.
- R7: A low pause pin seen during a low link-clock phase with chip select low pauses the block at once. With chip select high, no pause is entered.
- R8: A pause request made during a high link-clock phase takes effect only when the link clock next goes low.
- R9: A release during a low link-clock phase resumes at once. A release during a high phase resumes when the link clock next goes low.
- R10: While paused, the output enable is 0, link-clock and data transitions are ignored, and the bit position is kept, so the frame continues correctly after release.
- R11: Raising chip select while paused ends the pause and resets the frame. If chip select then falls while the pause pin is still low, the block pauses again. It resumes only once the pause pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Link clock pin |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_wp_n | input | 1 | Write guard, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Output enable for spi_so (0 = high impedance) |
| hold_active | output | 1 | Block is paused |
| cmd_strobe | output | 1 | One-cycle pulse on a complete opcode |
| cmd_code | output | 8 | Last opcode received |
| status_q | output | 8 | Status register contents |

## Verification
The hardest situations to reach are the deferred pause transitions, because they need the pause pin to move while the link clock is held high. The bench therefore drives the link clock one half-phase at a time. It changes the pause pin between the rising and falling halves and checks the pause flag both before and after the falling half. A read frame is also paused partway through with extra clock toggles, and the remaining bits must complete the byte correctly. Chip select is raised during a pause with the pause pin still low, which shows both that the frame is reset and that the pause comes back once chip select falls again. The guard sweep covers every pin and lock combination against an arithmetic model of the masked register.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] OPC_READ_SR  = 8'h05;
    localparam logic [BYTE_W-1:0] OPC_WRITE_SR = 8'h01;
    localparam logic [BYTE_W-1:0] SR_WRITABLE  = 8'h8C;

    // pin vector positions inside the synchroniser
    localparam int unsigned PIN_SCK  = 0;
    localparam int unsigned PIN_CS   = 1;
    localparam int unsigned PIN_HOLD = 2;
    localparam int unsigned PIN_WP   = 3;
    localparam int unsigned PIN_SI   = 4;
    localparam int unsigned PIN_N    = 5;

    typedef enum logic [1:0] {
        HS_RUN,
        HS_ENTER_WAIT,
        HS_PAUSED,
        HS_LEAVE_WAIT
    } hold_st_t;

    typedef enum logic [1:0] {
        CS_OPCODE,
        CS_WDATA,
        CS_RDATA,
        CS_DISCARD
    } cmd_st_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int unsigned WIDTH   = 5,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dprev
);

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_pin
            logic [STAGES:0] chain;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {(STAGES+1){RST_VAL[g]}};
                end else begin
                    chain <= {chain[STAGES-1:0], din[g]};
                end
            end

            assign dout[g]  = chain[STAGES-1];
            assign dprev[g] = chain[STAGES];
        end
    endgenerate

endmodule

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl
    import spi_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic cs_n_s,
    input  logic hold_n_s,
    output logic paused
);

    hold_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= HS_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        if (cs_n_s) begin
            st_d = HS_RUN;
        end else begin
            unique case (st_q)
                HS_RUN: begin
                    if (!hold_n_s) begin
                        st_d = sck_s ? HS_ENTER_WAIT : HS_PAUSED;
                    end
                end
                HS_ENTER_WAIT: begin
                    if (hold_n_s) begin
                        st_d = HS_RUN;
                    end else if (!sck_s) begin
                        st_d = HS_PAUSED;
                    end
                end
                HS_PAUSED: begin
                    if (hold_n_s) begin
                        st_d = sck_s ? HS_LEAVE_WAIT : HS_RUN;
                    end
                end
                HS_LEAVE_WAIT: begin
                    if (!hold_n_s) begin
                        st_d = HS_PAUSED;
                    end else if (!sck_s) begin
                        st_d = HS_RUN;
                    end
                end
            endcase
        end
    end

    always_comb begin
        paused = (st_q == HS_PAUSED) || (st_q == HS_LEAVE_WAIT);
    end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_fe_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter logic [DW-1:0] OP_RD = 8'h05,
    parameter logic [DW-1:0] OP_WR = 8'h01,
    parameter logic [DW-1:0] WMASK = 8'h8C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_s,
    input  logic          wp_n_s,
    input  logic          si_s,
    input  logic          sck_rise,
    input  logic          sck_fall,
    output logic          strobe,
    output logic [DW-1:0] code,
    output logic [DW-1:0] sr,
    output logic          so_bit,
    output logic          so_drive
);

    localparam int unsigned CNT_W = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW-1);

    cmd_st_t         st_q, st_d;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] rd_idx;
    logic [DW-1:0]   shreg;
    logic [DW-1:0]   shift_nxt;
    logic [DW-1:0]   snap;
    logic            byte_done;
    logic            wr_allowed;

    assign shift_nxt  = {shreg[DW-2:0], si_s};
    assign byte_done  = sck_rise && (bit_cnt == LAST_BIT);
    assign wr_allowed = wp_n_s || !sr[DW-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CS_OPCODE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (cs_n_s) begin
            st_d = CS_OPCODE;
        end else begin
            unique case (st_q)
                CS_OPCODE: begin
                    if (byte_done) begin
                        if (shift_nxt == OP_WR) begin
                            st_d = CS_WDATA;
                        end else if (shift_nxt == OP_RD) begin
                            st_d = CS_RDATA;
                        end else begin
                            st_d = CS_DISCARD;
                        end
                    end
                end
                CS_WDATA: begin
                    if (byte_done) begin
                        st_d = CS_DISCARD;
                    end
                end
                CS_RDATA:   st_d = CS_RDATA;
                CS_DISCARD: st_d = CS_DISCARD;
            endcase
        end
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rd_idx  <= '0;
            shreg   <= '0;
            snap    <= '0;
            so_bit  <= 1'b0;
            strobe  <= 1'b0;
            code    <= '0;
        end else if (cs_n_s) begin
            bit_cnt <= '0;
            rd_idx  <= '0;
            shreg   <= '0;
            so_bit  <= 1'b0;
            strobe  <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (sck_rise) begin
                shreg   <= shift_nxt;
                bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
            end
            if (byte_done && st_q == CS_OPCODE) begin
                strobe <= 1'b1;
                code   <= shift_nxt;
                snap   <= sr;
                rd_idx <= '0;
            end
            if (sck_fall && st_q == CS_RDATA) begin
                so_bit <= snap[DW-1-int'(rd_idx)];
                rd_idx <= (rd_idx == LAST_BIT) ? '0 : rd_idx + 1'b1;
            end
        end
    end

    // status register, kept across frames
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (!cs_n_s && st_q == CS_WDATA && byte_done && wr_allowed) begin
            sr <= shift_nxt & WMASK;
        end
    end

    always_comb begin
        so_drive = (st_q == CS_RDATA) && !cs_n_s;
    end

endmodule

// File: rtl/spi_hold_wp_front.sv
module spi_hold_wp_front
    import spi_fe_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DW = BYTE_W,
    parameter logic [DW-1:0] SR_WMASK = SR_WRITABLE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_cs_n,
    input  logic          spi_hold_n,
    input  logic          spi_wp_n,
    input  logic          spi_si,
    output logic          spi_so,
    output logic          spi_so_oe,
    output logic          hold_active,
    output logic          cmd_strobe,
    output logic [DW-1:0] cmd_code,
    output logic [DW-1:0] status_q
);

    localparam logic [PIN_N-1:0] PIN_IDLE = 5'b01110;

    logic [PIN_N-1:0] pin_raw, pin_s, pin_d;
    logic sck_s, cs_n_s, hold_n_s, wp_n_s, si_s;
    logic sck_rise, sck_fall;
    logic paused;
    logic so_bit, so_drive;

    assign pin_raw[PIN_SCK]  = spi_sck;
    assign pin_raw[PIN_CS]   = spi_cs_n;
    assign pin_raw[PIN_HOLD] = spi_hold_n;
    assign pin_raw[PIN_WP]   = spi_wp_n;
    assign pin_raw[PIN_SI]   = spi_si;

    spi_pin_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_raw),
        .dout (pin_s),
        .dprev(pin_d)
    );

    assign sck_s    = pin_s[PIN_SCK];
    assign cs_n_s   = pin_s[PIN_CS];
    assign hold_n_s = pin_s[PIN_HOLD];
    assign wp_n_s   = pin_s[PIN_WP];
    assign si_s     = pin_s[PIN_SI];

    spi_hold_ctl u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (sck_s),
        .cs_n_s  (cs_n_s),
        .hold_n_s(hold_n_s),
        .paused  (paused)
    );

    // link-clock edges are dropped while frozen
    assign sck_rise = sck_s && !pin_d[PIN_SCK] && !paused;
    assign sck_fall = !sck_s && pin_d[PIN_SCK] && !paused;

    spi_cmd_engine #(
        .DW   (DW),
        .OP_RD(DW'(OPC_READ_SR)),
        .OP_WR(DW'(OPC_WRITE_SR)),
        .WMASK(SR_WMASK)
    ) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (cs_n_s),
        .wp_n_s  (wp_n_s),
        .si_s    (si_s),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .strobe  (cmd_strobe),
        .code    (cmd_code),
        .sr      (status_q),
        .so_bit  (so_bit),
        .so_drive(so_drive)
    );

    always_comb begin
        hold_active = paused;
        spi_so_oe   = so_drive && !paused;
        spi_so      = so_bit;
    end

endmodule

// File: rtl/spi_hold_wp_front_chk.sv
module spi_hold_wp_front_chk #(
    parameter int unsigned DW = 8,
    parameter logic [DW-1:0] SR_WMASK = 8'h8C
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n_s,
    input logic          hold_n_s,
    input logic          sck_s,
    input logic          wp_n_s,
    input logic          hold_active,
    input logic          spi_so_oe,
    input logic          cmd_strobe,
    input logic [DW-1:0] status_q
);

    assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);

    assert_ro_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~SR_WMASK) == '0);

    assert_locked_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n_s && status_q[DW-1]) |=> $stable(status_q));

    assert_no_hold_without_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && !hold_active) |=> !hold_active);

    assert_enter_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_active && !cs_n_s && !hold_n_s && !sck_s) |=> hold_active);

    assert_enter_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_active && !cs_n_s && !hold_n_s && sck_s) |=> !hold_active);

    assert_leave_now_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && hold_n_s && !sck_s) |=> !hold_active);

    assert_leave_defer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && !cs_n_s && hold_n_s && sck_s) |=> hold_active);

    assert_so_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> !spi_so_oe);

    assert_no_strobe_in_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |=> !cmd_strobe);

    assert_ce_clears_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && cs_n_s) |=> !hold_active);

endmodule

bind spi_hold_wp_front spi_hold_wp_front_chk #(
    .DW      (DW),
    .SR_WMASK(SR_WMASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_s     (cs_n_s),
    .hold_n_s   (hold_n_s),
    .sck_s      (sck_s),
    .wp_n_s     (wp_n_s),
    .hold_active(hold_active),
    .spi_so_oe  (spi_so_oe),
    .cmd_strobe (cmd_strobe),
    .status_q   (status_q)
);

// File: tb/spi_hold_wp_front_bench.sv
`timescale 1ns/1ps
module spi_hold_wp_front_bench;

    localparam int HP = 6;
    localparam logic [7:0] MASK = 8'h8C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, wp_n = 1'b1, si = 1'b0;
    logic so, so_oe, held, strobe;
    logic [7:0] code, sr;

    int n_chk = 0, n_fail = 0, n_strobe = 0;
    logic [7:0] model = 8'h00;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_hold_wp_front u_spi_hold_wp_front (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_hold_n(hold_n), .spi_wp_n(wp_n), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .hold_active(held),
        .cmd_strobe(strobe), .cmd_code(code), .status_q(sr)
    );

    always @(posedge clk) if (strobe) n_strobe++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        si = b;
        tick(HP);
        r = so;
        sck = 1'b1;
        tick(HP);
        sck = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            xbit(t[i], b);
            r[i] = b;
        end
    endtask

    task automatic frame_start();
        cs_n = 1'b0;
        tick(HP);
    endtask

    task automatic frame_end();
        tick(HP);
        cs_n = 1'b1;
        tick(HP);
    endtask

    task automatic write_sr(input logic [7:0] v);
        logic [7:0] d;
        frame_start();
        xbyte(8'h01, d);
        xbyte(v, d);
        frame_end();
        if (wp_n || !model[7]) model = v & MASK;
    endtask

    task automatic read_sr(output logic [7:0] r);
        logic [7:0] d;
        frame_start();
        xbyte(8'h05, d);
        xbyte(8'h00, r);
        frame_end();
    endtask

    initial begin
        logic [7:0] r, r2, d;
        logic b;
        int s0;
        tick(4);
        rst_n = 1'b1;
        tick(6);

        // R1 reset state
        chk(sr == 8'h00, "R1 status", sr, 0);
        chk(held == 1'b0, "R1 hold flag", held, 0);
        chk(so_oe == 1'b0, "R1 so_oe", so_oe, 0);
        chk(strobe == 1'b0, "R1 strobe", strobe, 0);

        // R7: no pause while chip select high
        hold_n = 1'b0;
        tick(HP);
        chk(held == 1'b0, "R7 no pause without CE", held, 0);
        hold_n = 1'b1;
        tick(HP);

        // R2 + R3: read frame, repeated byte, opcode strobe
        wp_n = 1'b1;
        write_sr(8'h8C);
        s0 = n_strobe;
        frame_start();
        xbyte(8'h05, d);
        chk(code == 8'h05, "R2 opcode value", code, 8'h05);
        chk(n_strobe == s0 + 1, "R2 strobe count", n_strobe, s0 + 1);
        chk(so_oe == 1'b1, "R3 so_oe in read", so_oe, 1);
        xbyte(8'h00, r);
        xbyte(8'h00, r2);
        frame_end();
        chk(r == model, "R3 read byte", r, model);
        chk(r2 == model, "R3 repeated byte", r2, model);
        chk(so_oe == 1'b0, "R3 so_oe after frame", so_oe, 0);

        // R2: unknown opcode discards the rest of the frame
        s0 = n_strobe;
        frame_start();
        xbyte(8'hA5, d);
        chk(code == 8'hA5, "R2 unknown opcode value", code, 8'hA5);
        xbyte(8'h01, d);
        xbyte(8'h00, d);
        frame_end();
        chk(sr == model, "R2 unknown opcode ignored", sr, model);
        chk(n_strobe == s0 + 1, "R2 single strobe", n_strobe, s0 + 1);

        // R7/R9/R10: pause in low phase during read data, release in low phase
        frame_start();
        xbyte(8'h05, d);
        for (int i = 7; i >= 5; i--) begin
            xbit(1'b0, b);
            r[i] = b;
        end
        hold_n = 1'b0;
        tick(HP);
        chk(held == 1'b1, "R7 immediate pause", held, 1);
        chk(so_oe == 1'b0, "R10 so released in pause", so_oe, 0);
        for (int k = 0; k < 3; k++) begin
            si = ~si; sck = 1'b1; tick(HP); sck = 1'b0; tick(HP);
        end
        hold_n = 1'b1;
        tick(HP);
        chk(held == 1'b0, "R9 immediate release", held, 0);
        chk(so_oe == 1'b1, "R10 so driven again", so_oe, 1);
        for (int i = 4; i >= 0; i--) begin
            xbit(1'b0, b);
            r[i] = b;
        end
        frame_end();
        chk(r == model, "R10 read across pause", r, model);

        // R8/R9/R10: pause requested and released during the high phase
        s0 = n_strobe;
        frame_start();
        xbit(1'b0, b);
        xbit(1'b0, b);
        si = 1'b0; tick(HP); sck = 1'b1; tick(HP);
        hold_n = 1'b0;
        tick(HP);
        chk(held == 1'b0, "R8 pause deferred while high", held, 0);
        sck = 1'b0;
        tick(HP);
        chk(held == 1'b1, "R8 pause at low phase", held, 1);
        si = 1'b1; sck = 1'b1; tick(HP); sck = 1'b0; tick(HP);
        sck = 1'b1;
        tick(HP);
        hold_n = 1'b1;
        tick(HP);
        chk(held == 1'b1, "R9 release deferred while high", held, 1);
        sck = 1'b0;
        tick(HP);
        chk(held == 1'b0, "R9 release at low phase", held, 0);
        xbit(1'b0, b); xbit(1'b0, b); xbit(1'b1, b); xbit(1'b0, b); xbit(1'b1, b);
        chk(code == 8'h05, "R10 opcode intact after pause", code, 8'h05);
        chk(n_strobe == s0 + 1, "R10 one strobe after pause", n_strobe, s0 + 1);
        xbyte(8'h00, r);
        frame_end();
        chk(r == model, "R10 read after high-phase pause", r, model);

        // R11: chip select high while paused
        frame_start();
        xbit(1'b0, b); xbit(1'b0, b); xbit(1'b0, b);
        hold_n = 1'b0;
        tick(HP);
        chk(held == 1'b1, "R11 paused before abort", held, 1);
        cs_n = 1'b1;
        tick(HP);
        chk(held == 1'b0, "R11 abort clears pause", held, 0);
        cs_n = 1'b0;
        tick(HP);
        chk(held == 1'b1, "R11 pause returns with pin low", held, 1);
        hold_n = 1'b1;
        tick(HP);
        chk(held == 1'b0, "R11 resume with pin high", held, 0);
        xbyte(8'h05, d);
        chk(code == 8'h05, "R11 frame restarted", code, 8'h05);
        xbyte(8'h00, r);
        frame_end();
        chk(r == model, "R11 read after abort", r, model);

        // R4/R5/R6: guard pin x lock bit x data sweep
        for (int wpi = 0; wpi < 2; wpi++) begin
            for (int lk = 0; lk < 2; lk++) begin
                for (int k = 0; k < 16; k++) begin
                    logic [7:0] v;
                    v = 8'(k * 17);
                    wp_n = 1'b1;
                    write_sr({lk[0], 7'h04});
                    wp_n = wpi[0];
                    write_sr(v);
                    if (wpi == 1)
                        chk(sr == model, "R5 write with guard high", sr, model);
                    else
                        chk(sr == model, "R6 write with guard low", sr, model);
                    chk((sr & ~MASK) == 8'h00, "R4 read-only bits zero", sr, sr & MASK);
                    read_sr(r);
                    chk(r == model, "R3 serial status after write", r, model);
                end
            end
        end
        wp_n = 1'b1;
        write_sr(8'hFF);
        chk(sr == 8'h8C, "R4 all-ones write masked", sr, 8'h8C);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule